// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block collects several small platform control functions behind one synchronous register bus. Software uses it to hold a configuration byte, a diagnostic byte, a modem-control byte and a 16-bit diagnostic LED word. It also uses it to send a terminal-count strobe to a floppy controller, to ask the power supply to switch off, and to ask for a system reset. An external power-fail line is latched into a status bit. When an enable bit in the configuration byte is set, that status bit raises an interrupt.

Each bus access lasts one cycle and consists of an address, a write enable, write data and read data. Writes take effect at the clock edge. Reads are combinational from the stored values. The byte registers each sit at their own word address. The LED word and the system control word each occupy a four-word window, and only offset 0 of a window holds a register. The other registers are not plain storage: writes to them cause pulses and requests, and one bit clears the interrupt status when written with a one.

Top module: `aux_ctl_regs`

## Requirements
- R1: Reset clears the configuration, modem, aux-A and aux-B registers, and holds the pulse outputs at 0. The diagnostic byte, the LED word and the system control word keep their values through reset.
- R2: Word address 0 (configuration), 1 (diagnostic) and 2 (modem) store write data bits 7:0. Address 8 (LED) stores bits 15:0. Each reads back zero-extended in the same cycle. Unmapped addresses read 0.
- R3: A write to address 3 (aux-A) stores data bits 7:0 with bit 1 forced to 0. If data bit 1 is 1, fd_tc is high for exactly the one cycle after the write edge.
- R4: A write to address 4 (aux-B) keeps only data bits 1:0 and keeps the power-fail status (aux-B bit 5). If data bit 1 is 1, the status is cleared and only bit 0 is stored. Aux-B bit 1 never reads as 1.
- R5: pwr_off_req is a level equal to the stored aux-B bit 0.
- R6: When pwr_fail differs from its value at the previous edge, aux-B bit 5 is loaded with 1 only if pwr_fail is 1 and configuration bit 3 is 1. Otherwise it is loaded with 0. Without such a change, the bit holds.
- R7: irq is 1 exactly when aux-B bit 5 and configuration bit 3 are both 1. It follows configuration writes, aux-B writes and power-fail changes.
- R8: A write to address 12 (system control) with data bit 0 set loads the register with 0x2 and raises sys_rst_req for exactly the following cycle. With bit 0 clear, the write leaves the register unchanged and gives no request.
- R9: Addresses 9 to 11 (LED window) and 13 to 15 (system control window) read 0. Writes to them change no register and produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| pwr_fail | input | 1 | Power-fail indication |
| irq | output | 1 | Power-fail interrupt |
| fd_tc | output | 1 | One-cycle floppy terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request level |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with the default ADDR_W of 5. This makes the whole 32-word space reachable: every non-zero offset in both windows and every unmapped hole can be hit by random addresses alongside the live registers. Random writes, reads and power-fail toggles are compared against a bench model. Directed sequences cover the clear-by-one bit, the enable gating at the moment of a power-fail change, and the one-cycle width of both pulses.

// File: rtl/aux_ctl_regs.sv
module aux_ctl_regs #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              pwr_fail,
  output logic              irq,
  output logic              fd_tc,
  output logic              pwr_off_req,
  output logic              sys_rst_req
);
  localparam int WIN_LG = 2;
  localparam int WIN_W  = ADDR_W - WIN_LG;
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIAG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODEM = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_AUXA  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_AUXB  = ADDR_W'(4);
  localparam logic [WIN_W-1:0]  W_LED   = WIN_W'(2);
  localparam logic [WIN_W-1:0]  W_SYS   = WIN_W'(3);
  localparam int PFIE = 3, PFS = 5, OFF = 0, CLR = 1, TC = 1, GO = 0;

  logic [7:0]  cfg_q, diag_q, modem_q, auxa_q, auxb_q;
  logic [15:0] led_q;
  logic [31:0] sys_q;
  logic        pf_q, tc_q, rreq_q;

  wire led_win = addr[ADDR_W-1:WIN_LG] == W_LED;
  wire sys_win = addr[ADDR_W-1:WIN_LG] == W_SYS;
  wire at_zero = addr[WIN_LG-1:0] == '0;
  wire wr_cfg  = wr_en && addr == A_CFG;
  wire wr_auxa = wr_en && addr == A_AUXA;
  wire wr_auxb = wr_en && addr == A_AUXB;
  wire wr_led  = wr_en && led_win && at_zero;
  wire wr_sys  = wr_en && sys_win && at_zero;

  wire pf_evt = pwr_fail != pf_q;
  wire pfs_nx = pf_evt ? (pwr_fail & cfg_q[PFIE]) : auxb_q[PFS];
  wire clr_hit = wdata[CLR];

  logic [7:0] auxb_d;
  always_comb begin
    auxb_d = 8'h00;
    auxb_d[PFS] = pfs_nx;
    auxb_d[OFF] = auxb_q[OFF];
    if (wr_auxb) begin
      auxb_d[OFF] = wdata[OFF];
      if (clr_hit) auxb_d[PFS] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      modem_q <= '0;
      auxa_q  <= '0;
      auxb_q  <= '0;
      pf_q    <= 1'b0;
      tc_q    <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wdata[7:0];
      if (wr_en && addr == A_MODEM) modem_q <= wdata[7:0];
      if (wr_auxa) auxa_q <= wdata[7:0] & ~(8'h01 << TC);
      auxb_q <= auxb_d;
      pf_q   <= pwr_fail;
      tc_q   <= wr_auxa && wdata[TC];
      rreq_q <= wr_sys && wdata[GO];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr == A_DIAG) diag_q <= wdata[7:0];
    if (wr_led) led_q <= wdata[15:0];
    if (wr_sys && wdata[GO]) sys_q <= 32'h2;
  end

  always_comb begin
    rdata = '0;
    if (led_win) rdata = at_zero ? {16'h0, led_q} : '0;
    else if (sys_win) rdata = at_zero ? sys_q : '0;
    else case (addr)
      A_CFG:   rdata = {24'h0, cfg_q};
      A_DIAG:  rdata = {24'h0, diag_q};
      A_MODEM: rdata = {24'h0, modem_q};
      A_AUXA:  rdata = {24'h0, auxa_q};
      A_AUXB:  rdata = {24'h0, auxb_q};
      default: rdata = '0;
    endcase
  end

  assign irq         = auxb_q[PFS] & cfg_q[PFIE];
  assign fd_tc       = tc_q;
  assign pwr_off_req = auxb_q[OFF];
  assign sys_rst_req = rreq_q;

  a_r3_tc_from_write: assert property (@(posedge clk) disable iff (rst)
    fd_tc |-> $past(wr_en && addr == A_AUXA && wdata[TC]));
  a_r3_tc_bit_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_AUXA) |=> !auxa_q[TC]);
  a_r4_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_AUXB && wdata[CLR]) |=> !irq);
  a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(auxb_q[PFS]) |-> $past(cfg_q[PFIE] && pwr_fail));
  a_r8_req_status: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> sys_q == 32'h2);
  a_r8_req_from_write: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(wr_en && sys_win && at_zero && wdata[GO]));
endmodule

// File: tb/test_aux_ctl_regs.sv
module test_aux_ctl_regs;
  logic clk = 0, rst = 1, wr_en = 0, pwr_fail = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, fd_tc, pwr_off_req, sys_rst_req;
  int checks = 0, errors = 0;
  logic [7:0] m_cfg, m_diag, m_mdm, m_auxa, m_auxb;
  logic [15:0] m_led;
  logic [31:0] m_sys;
  logic m_pf = 0;

  always #2 clk = ~clk;

  aux_ctl_regs #(.ADDR_W(5)) i_aux_ctl_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pwr_fail(pwr_fail), .irq(irq), .fd_tc(fd_tc),
    .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd0: return {24'h0, m_cfg};
      5'd1: return {24'h0, m_diag};
      5'd2: return {24'h0, m_mdm};
      5'd3: return {24'h0, m_auxa};
      5'd4: return {24'h0, m_auxb};
      5'd8: return {16'h0, m_led};
      5'd12: return m_sys;
      default: return 32'h0;
    endcase
  endfunction

  task automatic levels();
    chk("R7 irq", {31'h0, irq}, {31'h0, m_auxb[5] & m_cfg[3]});
    chk("R5 pwr_off_req", {31'h0, pwr_off_req}, {31'h0, m_auxb[0]});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; #1;
    case (a)
      5'd0: m_cfg = d[7:0];
      5'd1: m_diag = d[7:0];
      5'd2: m_mdm = d[7:0];
      5'd3: m_auxa = d[7:0] & 8'hFD;
      5'd4: m_auxb = d[1] ? {7'h0, d[0]} : ((m_auxb & 8'h20) | {7'h0, d[0]});
      5'd8: m_led = d[15:0];
      5'd12: if (d[0]) m_sys = 32'h2;
      default: ;
    endcase
    chk("R3 fd_tc pulse", {31'h0, fd_tc}, {31'h0, a == 5'd3 && d[1]});
    chk("R8 sys_rst_req pulse", {31'h0, sys_rst_req}, {31'h0, a == 5'd12 && d[0]});
    levels();
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic setpf(input logic v);
    @(negedge clk); pwr_fail = v;
    @(negedge clk); #1;
    if (v != m_pf) m_auxb[5] = v & m_cfg[3];
    m_pf = v;
    levels();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    m_cfg = 0; m_mdm = 0; m_auxa = 0; m_auxb = 0; m_pf = pwr_fail;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1789);
    do_reset();
    #1;
    chk("R1 fd_tc reset", {31'h0, fd_tc}, 32'h0);
    chk("R1 sys_rst_req reset", {31'h0, sys_rst_req}, 32'h0);
    levels();
    rd("R1 cfg reset", 5'd0); rd("R1 modem reset", 5'd2);
    rd("R1 auxa reset", 5'd3); rd("R1 auxb reset", 5'd4);

    wr(5'd1, 32'hFFFF_FFA5); rd("R2 diag", 5'd1);
    wr(5'd2, 32'h0000_013C); rd("R2 modem", 5'd2);
    wr(5'd0, 32'h0000_0008); rd("R2 cfg", 5'd0);
    wr(5'd8, 32'hABCD_1234); rd("R2 led", 5'd8);
    rd("R2 unmapped", 5'd6); rd("R2 unmapped", 5'd31);
    wr(5'd12, 32'h0000_0001); rd("R8 sys set", 5'd12);
    wr(5'd12, 32'hFFFF_FFFE); rd("R8 sys unchanged", 5'd12);

    wr(5'd9, 32'hFFFF_FFFF); rd("R9 led kept", 5'd8); rd("R9 led off1", 5'd9);
    wr(5'd13, 32'hFFFF_FFFF); rd("R9 sys off1", 5'd13); rd("R9 sys kept", 5'd12);
    rd("R9 led off3", 5'd11); rd("R9 sys off3", 5'd15);

    wr(5'd3, 32'h0000_00FF); rd("R3 auxa bit1 dropped", 5'd3);
    @(negedge clk); #1; chk("R3 fd_tc one cycle", {31'h0, fd_tc}, 32'h0);
    wr(5'd3, 32'h0000_0041); rd("R3 auxa no pulse", 5'd3);

    setpf(1); rd("R6 status set", 5'd4);
    wr(5'd0, 32'h0); rd("R7 status kept", 5'd4);
    wr(5'd0, 32'h8);
    wr(5'd4, 32'h2); rd("R4 clear", 5'd4);
    setpf(0);
    wr(5'd0, 32'h0); setpf(1); rd("R6 needs enable", 5'd4);
    setpf(0); wr(5'd0, 32'h8); setpf(1);
    wr(5'd4, 32'h1); rd("R4 status kept", 5'd4);
    wr(5'd4, 32'h3); rd("R4 clr keeps bit0", 5'd4);
    wr(5'd4, 32'hFC); rd("R4 masked", 5'd4);
    setpf(0);

    wr(5'd0, 32'h8); setpf(1);
    do_reset();
    #1; levels();
    rd("R1 diag held", 5'd1); rd("R1 led held", 5'd8); rd("R1 sys held", 5'd12);
    rd("R1 cfg cleared", 5'd0); rd("R1 auxb cleared", 5'd4);
    setpf(0);

    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      op = $urandom_range(0, 99);
      if (op < 60) wr(5'($urandom_range(0, 31)), $urandom());
      else if (op < 70) wr(5'd4, 32'($urandom_range(0, 3)));
      else if (op < 85) rd("R2 random read", 5'($urandom_range(0, 31)));
      else setpf(1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule